// File: doc/BRIEF.md
# Passive LCD Panel Timing Generator

This block derives the raw strobes that drive a passive monochrome or grayscale LCD panel from one fixed master clock. A 6-bit pixel prescale value sets the length of one pixel period in master clocks. From that period the block builds a pixel-enable pulse for a downstream pixel shifter, the shift clock that moves data into the panel, the line clock that ends every line, a frame-start marker, and the AC bias output that the panel uses to reverse its drive polarity.

Each line is a run of shift-clock pulses followed by one line-clock pulse. The number of shift pulses depends on the line width in pixels and on the packing mode, because each shift clock moves a 4-bit data word. The shift-clock low phase that directly follows a line pulse lasts twice as long as the normal low phase. The AC bias output counts line pulses across frame boundaries, so it drifts against the frame rhythm on purpose. A zero pixel prescale is illegal and stops all timing. All configuration inputs are captured into shadow registers at frame boundaries, so writes made during a frame take effect with the next frame.

Top module: `lcdt_timing_gen`

## Requirements
- R1: With a captured pixel prescale P in the range 1 to 63, `pix_en` is a one-clock pulse that repeats every P+1 master clocks. One such period is a "slot".
- R2: While the captured prescale is zero, `pix_en`, `shift_clk`, `line_clk` and `frame_start` stay low, and `ac_bias` holds its value.
- R3: A shift-clock pulse is high for one slot and the normal low phase between two shift pulses lasts one slot. The low phase that directly follows a line-clock pulse lasts two slots.
- R4: `line_clk` is high for exactly one slot, in the slot after the last shift-clock high of the line, and `shift_clk` is low throughout that slot.
- R5: The number of shift-clock pulses per line is S = max(1, ceil(W*b/4)), where W is `line_pixels` and b is the bits per pixel from `bpp_mode`: code 2'b00 gives 1, 2'b01 gives 2, 2'b11 gives 4. The unused code 2'b10 behaves like 2'b00.
- R6: `frame_start` is high together with the line-clock pulse of the first line of each frame. Exactly N line pulses separate two frame starts, where N is `frame_lines`. A value of 0 behaves as 1.
- R7: `ac_bias` toggles on the (n+1)th line-clock pulse since its last toggle, where n is `ac_prescale`. The count carries across frame boundaries.
- R8: The configuration inputs are captured at the end of the last slot of each frame. While the captured prescale is zero they are captured on every clock, and timing restarts from the first slot of a new frame.
- R9: During reset and on the first clock after it, every output is low. The AC bias count starts at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_prescale | input | 6 | Pixel period minus one, in master clocks; 0 stops timing |
| ac_prescale | input | 5 | Line pulses per AC bias toggle minus one |
| line_pixels | input | 10 | Pixels per line |
| frame_lines | input | 9 | Lines per frame |
| bpp_mode | input | 2 | Pixel packing code (00: 1 bpp, 01: 2 bpp, 11: 4 bpp) |
| pix_en | output | 1 | One-clock pulse per pixel period |
| shift_clk | output | 1 | Panel shift clock |
| line_clk | output | 1 | Panel line clock |
| frame_start | output | 1 | Marks the line pulse of a frame's first line |
| ac_bias | output | 1 | Panel AC bias output |

## Verification
On every cycle the assertions check the following. A pixel-enable pulse never lasts two clocks. The strobes stay silent while the captured prescale is zero. The shift clock and the line clock are never high together. The shift clock is low as the line clock falls. The frame marker appears only inside a line pulse. The AC bias output changes only on a rising line pulse. Reset leaves every output low. The slot counts cannot be checked cycle by cycle and need the bench scenarios. These include the doubled low phase, the shift count for each packing mode, the lines per frame, the exact toggle distance of the AC bias across frame boundaries, and the delay until a mid-frame write takes effect.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

    typedef enum logic [1:0] {
        PACK_1BPP = 2'b00,
        PACK_2BPP = 2'b01,
        PACK_RSVD = 2'b10,
        PACK_4BPP = 2'b11
    } pack_mode_e;

    localparam int unsigned WORD_BITS = 4;

    // Shift pulses needed to move one line of W pixels through a 4-bit data word.
    function automatic int unsigned shifts_for(int unsigned width_px, logic [1:0] mode);
        int unsigned bits;
        int unsigned s;
        case (pack_mode_e'(mode))
            PACK_2BPP: bits = 2;
            PACK_4BPP: bits = 4;
            default:   bits = 1;
        endcase
        s = (width_px * bits + WORD_BITS - 1) / WORD_BITS;
        if (s == 0) s = 1;
        return s;
    endfunction

endpackage

// File: rtl/lcdt_pix_div.sv
module lcdt_pix_div #(
    parameter int PRE_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] pre,
    output logic             tick,
    output logic             pix_en
);
    typedef struct packed {
        logic [PRE_W-1:0] div;
        logic             pe;
    } div_state_t;

    div_state_t st_d, st_q;

    // Last master clock of the current slot.
    assign tick = run && (st_q.div >= pre);

    always_comb begin
        st_d    = st_q;
        st_d.pe = tick;
        if (!run) begin
            st_d.div = '0;
        end else if (tick) begin
            st_d.div = '0;
        end else begin
            st_d.div = st_q.div + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pix_en = st_q.pe;
endmodule

// File: rtl/lcdt_line_seq.sv
module lcdt_line_seq #(
    parameter int SHIFT_W = 10,
    parameter int LINE_W  = 9,
    parameter int SLOT_W  = SHIFT_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               tick,
    input  logic               slot_first,
    input  logic [SHIFT_W-1:0] shifts,
    input  logic [LINE_W-1:0]  lines,
    output logic               line_start,
    output logic               frame_end,
    output logic               shift_clk,
    output logic               line_clk,
    output logic               frame_start
);
    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [LINE_W-1:0] line;
        logic              cl2;
        logic              cl1;
        logic              fs;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic [SLOT_W-1:0] last_slot;
    logic              at_last_slot;
    logic              at_last_line;
    logic              in_shift_high;

    // Slots 0,1 low; even slots 2..2S high; slot 2S+1 carries the line pulse.
    assign last_slot     = {1'b0, shifts, 1'b1};
    assign at_last_slot  = (st_q.slot == last_slot);
    assign at_last_line  = ({1'b0, st_q.line} + (LINE_W+1)'(1)) >= {1'b0, lines};
    assign in_shift_high = !at_last_slot && !st_q.slot[0] && (st_q.slot >= SLOT_W'(2));

    assign line_start = run && at_last_slot && slot_first;
    assign frame_end  = tick && at_last_slot && at_last_line;

    always_comb begin
        st_d     = st_q;
        st_d.cl2 = run && in_shift_high;
        st_d.cl1 = run && at_last_slot;
        st_d.fs  = run && at_last_slot && (st_q.line == '0);
        if (!run) begin
            st_d.slot = '0;
            st_d.line = '0;
        end else if (tick) begin
            if (at_last_slot) begin
                st_d.slot = '0;
                st_d.line = at_last_line ? '0 : st_q.line + LINE_W'(1);
            end else begin
                st_d.slot = st_q.slot + SLOT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign shift_clk   = st_q.cl2;
    assign line_clk    = st_q.cl1;
    assign frame_start = st_q.fs;
endmodule

// File: rtl/lcdt_ac_bias.sv
module lcdt_ac_bias #(
    parameter int AC_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            line_start,
    input  logic [AC_W-1:0] ac,
    output logic            m_out
);
    typedef struct packed {
        logic [AC_W-1:0] cnt;
        logic            m;
    } ac_state_t;

    ac_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (line_start) begin
            if (st_q.cnt >= ac) begin
                st_d.cnt = '0;
                st_d.m   = !st_q.m;
            end else begin
                st_d.cnt = st_q.cnt + AC_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign m_out = st_q.m;
endmodule

// File: rtl/lcdt_timing_gen.sv
module lcdt_timing_gen #(
    parameter int PRE_W  = 6,
    parameter int AC_W   = 5,
    parameter int PIX_W  = 10,
    parameter int LINE_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PRE_W-1:0]  pix_prescale,
    input  logic [AC_W-1:0]   ac_prescale,
    input  logic [PIX_W-1:0]  line_pixels,
    input  logic [LINE_W-1:0] frame_lines,
    input  logic [1:0]        bpp_mode,
    output logic              pix_en,
    output logic              shift_clk,
    output logic              line_clk,
    output logic              frame_start,
    output logic              ac_bias
);
    localparam int SHIFT_W = PIX_W;
    localparam int SLOT_W  = SHIFT_W + 2;

    typedef struct packed {
        logic [PRE_W-1:0]   pre;
        logic [AC_W-1:0]    ac;
        logic [SHIFT_W-1:0] shifts;
        logic [LINE_W-1:0]  lines;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic run;
    logic tick;
    logic slot_first;
    logic line_start;
    logic frame_end;

    assign run = (cfg_q.pre != '0);

    always_comb begin
        cfg_d = cfg_q;
        if (!run || frame_end) begin
            cfg_d.pre    = pix_prescale;
            cfg_d.ac     = ac_prescale;
            cfg_d.shifts = SHIFT_W'(lcdt_pkg::shifts_for(32'(line_pixels), bpp_mode));
            cfg_d.lines  = frame_lines;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    lcdt_pix_div #(.PRE_W(PRE_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .pre    (cfg_q.pre),
        .tick   (tick),
        .pix_en (pix_en)
    );

    // First master clock of a slot: the divider has just wrapped to zero.
    logic first_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) first_q <= 1'b1;
        else        first_q <= tick || !run;
    end
    assign slot_first = first_q;

    lcdt_line_seq #(
        .SHIFT_W (SHIFT_W),
        .LINE_W  (LINE_W),
        .SLOT_W  (SLOT_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .tick        (tick),
        .slot_first  (slot_first),
        .shifts      (cfg_q.shifts),
        .lines       (cfg_q.lines),
        .line_start  (line_start),
        .frame_end   (frame_end),
        .shift_clk   (shift_clk),
        .line_clk    (line_clk),
        .frame_start (frame_start)
    );

    lcdt_ac_bias #(.AC_W(AC_W)) u_ac (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .ac         (cfg_q.ac),
        .m_out      (ac_bias)
    );
endmodule

// File: rtl/lcdt_timing_chk.sv
module lcdt_timing_chk (
    input logic clk,
    input logic rst_n,
    input logic run,
    input logic pix_en,
    input logic shift_clk,
    input logic line_clk,
    input logic frame_start,
    input logic ac_bias
);
    a_r1_pe_single: assert property (@(posedge clk) disable iff (!rst_n)
        pix_en |=> !pix_en);

    a_r2_stopped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!pix_en && !shift_clk && !line_clk && !frame_start));

    a_r3_low_after_line: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_clk) |-> !shift_clk);

    a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_clk && shift_clk));

    a_r6_fs_in_line: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> line_clk);

    a_r7_m_on_line: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ac_bias) |-> $rose(line_clk));

    a_r9_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!pix_en && !shift_clk && !line_clk && !frame_start && !ac_bias));
endmodule

bind lcdt_timing_gen lcdt_timing_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .pix_en      (pix_en),
    .shift_clk   (shift_clk),
    .line_clk    (line_clk),
    .frame_start (frame_start),
    .ac_bias     (ac_bias)
);

// File: tb/lcdt_timing_gen_bench.sv
`timescale 1ns/1ps
module lcdt_timing_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] pix_prescale = '0;
    logic [4:0] ac_prescale = '0;
    logic [9:0] line_pixels = '0;
    logic [8:0] frame_lines = '0;
    logic [1:0] bpp_mode = '0;
    logic pix_en, shift_clk, line_clk, frame_start, ac_bias;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = !clk;

    lcdt_timing_gen u_lcdt_timing_gen (
        .clk(clk), .rst_n(rst_n), .pix_prescale(pix_prescale), .ac_prescale(ac_prescale),
        .line_pixels(line_pixels), .frame_lines(frame_lines), .bpp_mode(bpp_mode),
        .pix_en(pix_en), .shift_clk(shift_clk), .line_clk(line_clk),
        .frame_start(frame_start), .ac_bias(ac_bias)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(string req, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic int exp_shifts(int w, int md);
        int b;
        int s;
        b = (md == 3) ? 4 : (md == 1) ? 2 : 1;
        s = (w * b + 3) / 4;
        return (s < 1) ? 1 : s;
    endfunction

    task automatic setcfg(int p, int w, int md, int nl, int acn);
        pix_prescale = 6'(p);
        line_pixels  = 10'(w);
        bpp_mode     = 2'(md);
        frame_lines  = 9'(nl);
        ac_prescale  = 5'(acn);
    endtask

    task automatic wait_fs_fall();
        while (!frame_start) tick();
        while (frame_start) tick();
    endtask

    task automatic m_check(int acn);
        int cnt = 0;
        bit armed = 0;
        bit done = 0;
        logic pm = ac_bias;
        logic pl = line_clk;
        while (!done) begin
            tick();
            if (line_clk && !pl) cnt++;
            if (ac_bias != pm) begin
                if (armed) begin
                    chk("R7 line pulses per toggle", cnt, acn + 1);
                    done = 1;
                end
                armed = 1;
                cnt = 0;
            end
            pm = ac_bias;
            pl = line_clk;
        end
    endtask

    task automatic meas(int p, int w, int md, int nl, int acn);
        int s, lo, hi, gap, sh, w1, cnt, c;
        logic prv;
        s = exp_shifts(w, md);
        wait_fs_fall();
        wait_fs_fall();
        lo = 1;
        while (!shift_clk) begin tick(); if (!shift_clk) lo++; end
        chk("R3 stretched low after line pulse", lo, 2 * (p + 1));
        hi = 1;
        while (shift_clk) begin tick(); if (shift_clk) hi++; end
        chk("R3 shift high width", hi, p + 1);
        gap = line_clk ? 0 : 1;
        while (!shift_clk && !line_clk) begin
            tick();
            if (!shift_clk && !line_clk) gap++;
        end
        if (s > 1) chk("R3 normal low width", gap, p + 1);
        sh = 1;
        if (shift_clk) sh++;
        prv = shift_clk;
        while (!line_clk) begin
            tick();
            if (shift_clk && !prv) sh++;
            prv = shift_clk;
        end
        chk("R5 shift pulses per line", sh, s);
        w1 = 1;
        while (line_clk) begin tick(); if (line_clk) w1++; end
        chk("R4 line pulse width", w1, p + 1);
        while (!frame_start) tick();
        cnt = 0;
        prv = 1'b1;
        forever begin
            tick();
            if (line_clk && !prv) begin
                cnt++;
                if (frame_start) break;
            end
            prv = line_clk;
        end
        chk("R6 lines per frame", cnt, (nl < 1) ? 1 : nl);
        while (!pix_en) tick();
        c = 0;
        do begin tick(); c++; end while (!pix_en);
        chk("R1 pixel enable period", c, p + 1);
        m_check(acn);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int seed;
        int q, act, mchg;
        logic pm;
        seed = $urandom(32'h1cd5);
        repeat (4) tick();
        chk("R9 reset outputs", {pix_en, shift_clk, line_clk, frame_start, ac_bias}, 0);
        rst_n = 1'b1;
        tick();
        chk("R9 first clock after reset", {pix_en, shift_clk, line_clk, frame_start, ac_bias}, 0);

        // R7: toggle distance of 13 lines crosses 5-line frames
        setcfg(1, 4, 0, 5, 12);
        meas(1, 4, 0, 5, 12);
        // R5: each packing code
        setcfg(2, 9, 3, 3, 2);  meas(2, 9, 3, 3, 2);
        setcfg(2, 9, 1, 2, 1);  meas(2, 9, 1, 2, 1);
        setcfg(1, 9, 2, 1, 0);  meas(1, 9, 2, 1, 0);
        setcfg(3, 0, 0, 0, 3);  meas(3, 0, 0, 0, 3);

        for (int i = 0; i < 9; i++) begin
            int p, w, md, nl, acn;
            p   = 1 + int'($urandom % 5);
            w   = 1 + int'($urandom % 16);
            md  = int'($urandom % 4);
            nl  = 1 + int'($urandom % 6);
            acn = int'($urandom % 8);
            setcfg(p, w, md, nl, acn);
            meas(p, w, md, nl, acn);
        end

        // R8: a mid-frame write waits for the frame boundary
        setcfg(2, 4, 3, 4, 3);
        meas(2, 4, 3, 4, 3);
        wait_fs_fall();
        pix_prescale = 6'd5;
        while (!line_clk) tick();
        q = 0;
        while (line_clk) begin tick(); q++; end
        chk("R8 old prescale kept mid-frame", q, 3);
        meas(5, 4, 3, 4, 3);

        // R2: zero prescale stops everything
        pix_prescale = 6'd0;
        q = 0;
        while (q < 100) begin tick(); q = pix_en ? 0 : q + 1; end
        act = 0;
        mchg = 0;
        pm = ac_bias;
        for (int k = 0; k < 600; k++) begin
            tick();
            if (pix_en || shift_clk || line_clk || frame_start) act++;
            if (ac_bias != pm) mchg++;
            pm = ac_bias;
        end
        chk("R2 strobes while stopped", act, 0);
        chk("R2 ac bias held while stopped", mchg, 0);

        // R8: capture while stopped restarts at once
        setcfg(3, 6, 1, 3, 4);
        q = 0;
        while (!line_clk && q < 1000) begin tick(); q++; end
        chk("R8 restart line pulse seen", int'(line_clk), 1);
        meas(3, 6, 1, 3, 4);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule